// File: doc/BRIEF.md
# I2C Event Status and Interrupt Vector Unit

This unit sits beside the bit-level engine of an I2C master controller and collects the events that engine reports. The events are arbitration lost, no acknowledge, access ready, receive ready, transmit ready, receive overrun and transmit underflow, and each arrives as a single-cycle pulse. Each event sets a sticky bit in a 16-bit status word. A 16-bit enable word selects which of the five interrupt-capable events may assert the single interrupt line. The live bus-busy level appears in the same status word, so software can poll it before it starts a transfer.

Software sees the events in two ways. A modern handler reads the status word, acts on it, and writes ones back to clear the bits it handled. A legacy handler reads a small vector code instead. The code names the pending, enabled event with the highest priority, and the read that returns the code also clears that event. Both views share one status store, so the two kinds of handler stay consistent.

Access uses a simple 16-bit register port. Read data is a combinational function of the address. A write, or the side effect of a read, takes effect at the next rising clock edge.

Top module: `i2c_evt_irq_unit`

## Requirements
- R1: After reset the status word, the enable word and the vector code are all zero, and the interrupt line is low.
- R2: An event pulse sets its status bit at the next clock edge, and the bit stays set until it is cleared. The bit positions are: arbitration lost 0, no acknowledge 1, access ready 2, receive ready 3, transmit ready 4, transmit underflow 10, receive overrun 11. The status word is read at byte offset 0x08.
- R3: In a write to offset 0x08, each data bit at 1 clears the matching sticky status bit, and each data bit at 0 leaves its status bit as it was.
- R4: When an event pulse and a clear of the same bit arrive in the same cycle, the bit ends up set. The clear can come from a status write or from a vector read.
- R5: Status bit 12 shows the bus_busy input live, and a status write cannot clear it. Status bits 5 to 9 and 13 to 15 always read 0.
- R6: The enable word at offset 0x04 is read/write in bits 0 to 4. Each of these bits uses the same position as its event in the status word. Bits 5 to 15 read 0 regardless of the data written.
- R7: The interrupt line is high exactly when the registered status bits 0 to 4 ANDed with the enable bits 0 to 4 are nonzero.
- R8: The vector register at offset 0x0C returns 0 when no enabled event is pending. Otherwise it returns the lowest code among the pending enabled events: 1 arbitration lost, 2 no acknowledge, 3 access ready, 4 receive ready, 5 transmit ready.
- R9: A read strobe at offset 0x0C clears the status bit of the event the vector reports at the next clock edge. A vector read that returns 0 changes nothing.
- R10: A write to offset 0x0C, or to any offset other than 0x04 and 0x08, changes no state. A read at any offset other than 0x04, 0x08 and 0x0C returns 0.
- R11: Transmit underflow and receive overrun are recorded in the status word only. They never assert the interrupt line and never appear in the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_arb_lost_i | input | 1 | Arbitration lost event pulse |
| ev_nack_i | input | 1 | No-acknowledge event pulse |
| ev_acc_rdy_i | input | 1 | Access ready event pulse |
| ev_rx_rdy_i | input | 1 | Receive ready event pulse |
| ev_tx_rdy_i | input | 1 | Transmit ready event pulse |
| ev_rx_ovr_i | input | 1 | Receive overrun event pulse |
| ev_tx_udf_i | input | 1 | Transmit underflow event pulse |
| bus_busy_i | input | 1 | Live bus-busy level from the engine |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe (side effect only at the vector offset) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the current offset |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the properties that hold whatever the stimulus:
- an event pulse leaves its bit set, including when a clear lands in the same cycle;
- a sticky bit falls only after a matching clear;
- the interrupt line agrees with a nonzero vector;
- every nonzero vector points at a bit that is both set and enabled;
- a vector read removes the reported event.

Some behaviour only the bench scenarios can show:
- that bit 12 tracks the bus-busy level;
- that reserved and unmapped locations read zero;
- that writes to the vector and unmapped offsets leave all state alone;
- that the vector walks through the priority order as successive reads drain it;
- that underflow and overrun stay out of the interrupt.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

    localparam int REG_W   = 16;
    localparam int N_SRC   = 5;
    localparam int CODE_W  = $clog2(N_SRC + 1);

    // status bit positions decoded by software
    localparam int B_AL    = 0;
    localparam int B_NACK  = 1;
    localparam int B_ARDY  = 2;
    localparam int B_RRDY  = 3;
    localparam int B_XRDY  = 4;
    localparam int B_XUDF  = 10;
    localparam int B_ROVR  = 11;
    localparam int B_BUSY  = 12;

    // bits that latch events and clear on write-one
    localparam logic [REG_W-1:0] STICKY_MASK =
        REG_W'((1 << B_AL) | (1 << B_NACK) | (1 << B_ARDY) | (1 << B_RRDY) |
               (1 << B_XRDY) | (1 << B_XUDF) | (1 << B_ROVR));

endpackage

// File: rtl/i2c_evt_status.sv
module i2c_evt_status #(
    parameter int               REG_W       = 16,
    parameter logic [REG_W-1:0] STICKY_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_i,
    input  logic [REG_W-1:0] clr_i,
    output logic [REG_W-1:0] stat_o
);

    typedef struct packed {
        logic [REG_W-1:0] stat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < REG_W; i++) begin
            if (STICKY_MASK[i]) begin
                // a new event overrides a clear landing in the same cycle
                st_d.stat[i] = set_i[i] | (st_q.stat[i] & ~clr_i[i]);
            end else begin
                st_d.stat[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;

endmodule

// File: rtl/i2c_evt_prio.sv
module i2c_evt_prio #(
    parameter int N_SRC  = 5,
    parameter int CODE_W = $clog2(N_SRC + 1)
) (
    input  logic [N_SRC-1:0]  pend_i,
    output logic [CODE_W-1:0] code_o,
    output logic [N_SRC-1:0]  pick_o
);

    // scan from the top so the lowest index is the one that remains
    always_comb begin
        code_o = '0;
        pick_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                code_o    = CODE_W'(i + 1);
                pick_o    = '0;
                pick_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2c_evt_regif.sv
module i2c_evt_regif #(
    parameter int               ADDR_W      = 8,
    parameter int               REG_W       = 16,
    parameter int               N_SRC       = 5,
    parameter int               CODE_W      = 3,
    parameter int               OFS_EN      = 4,
    parameter int               OFS_STAT    = 8,
    parameter int               OFS_VEC     = 12,
    parameter int               BUSY_BIT    = 12,
    parameter logic [REG_W-1:0] STICKY_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [REG_W-1:0]  stat_i,
    input  logic              busy_i,
    input  logic [CODE_W-1:0] vec_i,
    input  logic [N_SRC-1:0]  pick_i,
    output logic [N_SRC-1:0]  en_o,
    output logic [REG_W-1:0]  clr_o,
    output logic [REG_W-1:0]  rdata_o
);

    typedef struct packed {
        logic [N_SRC-1:0] en;
    } rs_t;

    rs_t rs_d, rs_q;

    logic sel_en, sel_stat, sel_vec;

    assign sel_en   = (addr_i == ADDR_W'(OFS_EN));
    assign sel_stat = (addr_i == ADDR_W'(OFS_STAT));
    assign sel_vec  = (addr_i == ADDR_W'(OFS_VEC));

    always_comb begin
        rs_d = rs_q;
        if (wr_i && sel_en) begin
            rs_d.en = wdata_i[N_SRC-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    // clear requests: write-one at status, or consume on vector read
    always_comb begin
        clr_o = '0;
        if (wr_i && sel_stat) begin
            clr_o = wdata_i & STICKY_MASK;
        end
        if (rd_i && sel_vec) begin
            clr_o = clr_o | REG_W'(pick_i);
        end
    end

    always_comb begin
        rdata_o = '0;
        if (sel_en) begin
            rdata_o = REG_W'(rs_q.en);
        end else if (sel_stat) begin
            rdata_o           = stat_i;
            rdata_o[BUSY_BIT] = busy_i;
        end else if (sel_vec) begin
            rdata_o = REG_W'(vec_i);
        end
    end

    assign en_o = rs_q.en;

endmodule

// File: rtl/i2c_evt_irq_unit.sv
module i2c_evt_irq_unit
    import i2c_evt_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int OFS_EN   = 4,
    parameter int OFS_STAT = 8,
    parameter int OFS_VEC  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_arb_lost_i,
    input  logic              ev_nack_i,
    input  logic              ev_acc_rdy_i,
    input  logic              ev_rx_rdy_i,
    input  logic              ev_tx_rdy_i,
    input  logic              ev_rx_ovr_i,
    input  logic              ev_tx_udf_i,
    input  logic              bus_busy_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_o
);

    logic [REG_W-1:0]  set_vec;
    logic [REG_W-1:0]  clr_vec;
    logic [REG_W-1:0]  stat_q;
    logic [N_SRC-1:0]  en_q;
    logic [N_SRC-1:0]  pend;
    logic [N_SRC-1:0]  pick;
    logic [CODE_W-1:0] vec_code;

    always_comb begin
        set_vec         = '0;
        set_vec[B_AL]   = ev_arb_lost_i;
        set_vec[B_NACK] = ev_nack_i;
        set_vec[B_ARDY] = ev_acc_rdy_i;
        set_vec[B_RRDY] = ev_rx_rdy_i;
        set_vec[B_XRDY] = ev_tx_rdy_i;
        set_vec[B_XUDF] = ev_tx_udf_i;
        set_vec[B_ROVR] = ev_rx_ovr_i;
    end

    i2c_evt_status #(
        .REG_W       (REG_W),
        .STICKY_MASK (STICKY_MASK)
    ) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .stat_o (stat_q)
    );

    assign pend = stat_q[N_SRC-1:0] & en_q;

    i2c_evt_prio #(
        .N_SRC  (N_SRC),
        .CODE_W (CODE_W)
    ) u_prio (
        .pend_i (pend),
        .code_o (vec_code),
        .pick_o (pick)
    );

    i2c_evt_regif #(
        .ADDR_W      (ADDR_W),
        .REG_W       (REG_W),
        .N_SRC       (N_SRC),
        .CODE_W      (CODE_W),
        .OFS_EN      (OFS_EN),
        .OFS_STAT    (OFS_STAT),
        .OFS_VEC     (OFS_VEC),
        .BUSY_BIT    (B_BUSY),
        .STICKY_MASK (STICKY_MASK)
    ) u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr_i),
        .wr_i    (reg_wr_i),
        .rd_i    (reg_rd_i),
        .wdata_i (reg_wdata_i),
        .stat_i  (stat_q),
        .busy_i  (bus_busy_i),
        .vec_i   (vec_code),
        .pick_i  (pick),
        .en_o    (en_q),
        .clr_o   (clr_vec),
        .rdata_o (reg_rdata_o)
    );

    assign irq_o = |pend;

endmodule

// File: rtl/i2c_evt_irq_chk.sv
module i2c_evt_irq_chk #(
    parameter int ADDR_W   = 8,
    parameter int OFS_STAT = 8,
    parameter int OFS_VEC  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_al,
    input logic              ev_nack,
    input logic              wr,
    input logic              rd,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       wdata,
    input logic [15:0]       stat,
    input logic [4:0]        en,
    input logic [2:0]        vec,
    input logic              irq
);

    logic wr_stat, rd_vec;
    assign wr_stat = wr && (addr == ADDR_W'(OFS_STAT));
    assign rd_vec  = rd && (addr == ADDR_W'(OFS_VEC));

    p_al_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_al |=> stat[0]);

    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[1] && !ev_nack) |=> !stat[1]);

    p_fall_needs_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat[1]) |-> $past((wr_stat && wdata[1]) || (rd_vec && vec == 3'd2)));

    p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_nack && wr_stat && wdata[1]) |=> stat[1]);

    p_irq_vec_agree_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (vec != 3'd0));

    p_vec_points_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec != 3'd0) |-> (stat[vec - 3'd1] && en[vec - 3'd1]));

    p_vec_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec && vec == 3'd1 && !ev_al) |=> !stat[0]);

endmodule

bind i2c_evt_irq_unit i2c_evt_irq_chk #(
    .ADDR_W   (ADDR_W),
    .OFS_STAT (OFS_STAT),
    .OFS_VEC  (OFS_VEC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_al   (ev_arb_lost_i),
    .ev_nack (ev_nack_i),
    .wr      (reg_wr_i),
    .rd      (reg_rd_i),
    .addr    (reg_addr_i),
    .wdata   (reg_wdata_i),
    .stat    (stat_q),
    .en      (en_q),
    .vec     (vec_code),
    .irq     (irq_o)
);

// File: tb/i2c_evt_irq_unit_tb.sv
`timescale 1ns/1ps
module i2c_evt_irq_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  ev = '0;   // 0 AL,1 NACK,2 ARDY,3 RRDY,4 XRDY,5 XUDF,6 ROVR
    logic        bb = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int errs   = 0;
    logic [15:0] m_stat = '0;
    logic [4:0]  m_en   = '0;

    always #2 clk = ~clk;

    i2c_evt_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .ev_arb_lost_i(ev[0]), .ev_nack_i(ev[1]), .ev_acc_rdy_i(ev[2]),
        .ev_rx_rdy_i(ev[3]), .ev_tx_rdy_i(ev[4]),
        .ev_tx_udf_i(ev[5]), .ev_rx_ovr_i(ev[6]),
        .bus_busy_i(bb), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [15:0] ev2stat(input logic [6:0] e);
        logic [15:0] s = '0;
        s[4:0] = e[4:0];
        s[10]  = e[5];
        s[11]  = e[6];
        return s;
    endfunction

    function automatic logic [2:0] f_vec(input logic [15:0] s, input logic [4:0] en);
        logic [2:0] v = 3'd0;
        for (int i = 4; i >= 0; i--) if (s[i] && en[i]) v = 3'(i + 1);
        return v;
    endfunction

    function automatic logic [15:0] f_rd(input logic [7:0] a, input logic b);
        case (a)
            8'h04:   return {11'd0, m_en};
            8'h08:   return m_stat | (16'(b) << 12);
            8'h0C:   return {13'd0, f_vec(m_stat, m_en)};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // one bus cycle: drive at negedge, check, then update model at posedge
    task automatic cyc(input logic [6:0] e, input logic b, input logic w, input logic r,
                       input logic [7:0] a, input logic [15:0] d);
        logic [15:0] clr;
        logic [2:0]  v;
        @(negedge clk);
        ev = e; bb = b; wr = w; rd = r; addr = a; wdata = d;
        #1;
        chk("R7 irq", {15'd0, irq}, {15'd0, |(m_stat[4:0] & m_en)});
        case (a)
            8'h04:   chk("R6 enable", rdata, f_rd(a, b));
            8'h08:   chk("R2 status", rdata, f_rd(a, b));
            8'h0C:   chk("R8 vector", rdata, f_rd(a, b));
            default: chk("R10 unmapped", rdata, f_rd(a, b));
        endcase
        @(posedge clk);
        clr = '0;
        v = f_vec(m_stat, m_en);
        if (w && a == 8'h08) clr = d & 16'h0C1F;
        if (r && a == 8'h0C && v != 3'd0) clr[v - 3'd1] = 1'b1;
        m_stat = (m_stat & ~clr) | ev2stat(e);
        if (w && a == 8'h04) m_en = d[4:0];
    endtask

    task automatic idle(input logic [7:0] a);
        cyc(7'd0, bb, 1'b0, 1'b0, a, 16'h0);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        #(4 * 150000);
        errs++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        idle(8'h08); idle(8'h04); idle(8'h0C);
        chk("R1 vector", rdata, 16'd0);

        // R6: only bits 0-4 of enable stick
        cyc(7'd0, 1'b0, 1'b1, 1'b0, 8'h04, 16'hFFFF);
        idle(8'h04);
        chk("R6 reserved", rdata, 16'h001F);

        // R2: AL pulse latches and holds
        cyc(7'b0000001, 1'b0, 1'b0, 1'b0, 8'h08, 16'h0);
        idle(8'h08); idle(8'h08);
        chk("R2 sticky AL", rdata, 16'h0001);

        // R4: NACK event and W1C of bit 1 together: event wins
        cyc(7'b0000010, 1'b0, 1'b1, 1'b0, 8'h08, 16'h0002);
        idle(8'h08);
        chk("R4 event wins", rdata, 16'h0003);

        // R3: writing zeros changes nothing, writing one clears
        cyc(7'd0, 1'b0, 1'b1, 1'b0, 8'h08, 16'h0000);
        idle(8'h08);
        chk("R3 zero write", rdata, 16'h0003);
        cyc(7'd0, 1'b0, 1'b1, 1'b0, 8'h08, 16'h0002);
        idle(8'h08);
        chk("R3 one clears", rdata, 16'h0001);

        // R8/R9: vector drains in priority order
        cyc(7'b0011100, 1'b0, 1'b0, 1'b0, 8'h0C, 16'h0);
        for (int k = 1; k <= 5; k++) begin
            if (k == 2) continue;
            cyc(7'd0, 1'b0, 1'b0, 1'b1, 8'h0C, 16'h0);
            chk("R9 vector code", rdata, 16'(k));
        end
        idle(8'h0C);
        chk("R9 drained", rdata, 16'd0);
        cyc(7'd0, 1'b0, 1'b0, 1'b1, 8'h0C, 16'h0);   // empty read: nothing
        chk("R9 irq low", {15'd0, irq}, 16'd0);

        // R8: disabled event does not appear in the vector
        cyc(7'd0, 1'b0, 1'b1, 1'b0, 8'h04, 16'h0004);
        cyc(7'b0000001, 1'b0, 1'b0, 1'b0, 8'h0C, 16'h0);
        idle(8'h0C);
        chk("R8 masked", rdata, 16'd0);
        cyc(7'd0, 1'b0, 1'b1, 1'b0, 8'h04, 16'h001F);
        idle(8'h0C);
        chk("R8 unmasked", rdata, 16'd1);

        // R10: writes to vector and unmapped offsets are ignored
        cyc(7'd0, 1'b0, 1'b1, 1'b0, 8'h0C, 16'hFFFF);
        cyc(7'd0, 1'b0, 1'b1, 1'b0, 8'h00, 16'hFFFF);
        cyc(7'd0, 1'b0, 1'b1, 1'b0, 8'h10, 16'hFFFF);
        idle(8'h08);
        chk("R10 status kept", rdata, 16'h0001);
        idle(8'h04);
        chk("R10 enable kept", rdata, 16'h001F);
        cyc(7'd0, 1'b0, 1'b1, 1'b0, 8'h08, 16'hFFFF);

        // R5: bus busy is live and not write-clearable
        cyc(7'd0, 1'b1, 1'b1, 1'b0, 8'h08, 16'h1000);
        idle(8'h08);
        chk("R5 busy live", rdata, 16'h1000);
        cyc(7'd0, 1'b0, 1'b0, 1'b0, 8'h08, 16'h0);
        chk("R5 busy drop", rdata, 16'h0000);

        // R11: underflow/overrun never raise irq
        cyc(7'b1100000, 1'b0, 1'b0, 1'b0, 8'h08, 16'h0);
        idle(8'h0C);
        chk("R11 vector", rdata, 16'd0);
        chk("R11 irq", {15'd0, irq}, 16'd0);
        idle(8'h08);
        chk("R11 status", rdata, 16'h0C00);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [7:0]  a;
            logic [6:0]  e;
            int sel;
            sel = $urandom % 8;
            case (sel)
                0, 1, 2: a = 8'h08;
                3:       a = 8'h04;
                4, 5:    a = 8'h0C;
                6:       a = 8'h00;
                default: a = 8'($urandom);
            endcase
            for (int b = 0; b < 7; b++) e[b] = (($urandom % 8) == 0);
            cyc(e, 1'($urandom), ($urandom % 4) == 0, ($urandom % 3) == 0, a,
                16'($urandom));
        end

        summary();
        $finish;
    end

endmodule